// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the full strobe sequence of an 8-bit multiplexed NAND flash bus. Commands, address bytes and data bytes all travel over the same eight I/O lines. The command and address latch enables tell the device which kind of byte is present, and the device latches each byte when write-enable rises. The host supplies an operation code, a 23-bit flash address, a byte count and, for programs, a stream of write bytes. The block supplies chip enable, the two latch enables, write-enable and read-enable, and it drives or releases the I/O lines.

For program and erase, the block waits for the ready/busy line after the confirm command. It then reads the status byte and reports pass or fail. For page reads, it waits for the array load to finish before clocking the data out. Write-enable and read-enable pulse widths are set at run time in system clocks. Reset and status requests are accepted while the device is busy; every other request is turned away with a one-cycle reject pulse.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command byte is presented with CLE=1 and ALE=0, an address byte with ALE=1 and CLE=0, and a data byte with both low. CLE and ALE are never high together, and the byte on the bus is valid when WE rises.
- R2: Address bytes go out lowest first: A7..A0, then A16..A9, then {2'b00, A22..A17}. A8 is never put on the bus.
- R3: Operation code 0 (program) sends 80h, three address bytes, the data bytes in host order, then 10h.
- R4: Operation code 4 (erase) sends 60h, only the two upper address bytes (A16..A9, then A22..A17), then D0h.
- R5: Operation codes 1, 2 and 3 (reads) send 00h, 01h and 50h respectively, then three address bytes. After the busy period, count bytes are delivered on rd_data with rd_valid.
- R6: After a program or erase confirm, and after the last read address byte, no WE or RE pulse occurs while nf_rb is low.
- R7: After a program or erase completes, the block sends 70h, reads one byte, and op_fail equals bit 0 of that byte when op_done pulses.
- R8: For a program, the column is {A8, A7..A0}, and at most 528 minus that column data bytes are sent. Extra host bytes are never requested.
- R9: When idle with nf_rb low, a request with operation code 6 (reset, FFh) or 7 (status, 70h plus one byte returned) is accepted. Any other request yields req_reject for one cycle, and no bus activity follows.
- R10: Operation code 5 (read ID) sends 90h, one address byte 00h, then reads count bytes. Each read byte is taken while RE is low, after its falling edge.
- R11: WE and RE low times equal their configured clock counts, and configured values below 2 act as 2.
- R12: nf_ce_n stays low from the first command to the last bus cycle of an operation, rising once per operation. nf_io_oe is low whenever RE is low or the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 3 | Operation code (see R3 to R10) |
| req_addr | input | 23 | Flash address A22..A0 |
| req_count | input | 10 | Number of data bytes |
| req_ready | output | 1 | Block idle, request may be taken |
| req_reject | output | 1 | One-cycle pulse: request refused while busy |
| wr_data | input | 8 | Current write byte from host |
| wr_ack | output | 1 | Pulse: current write byte was taken, present next |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data valid this cycle |
| op_done | output | 1 | One-cycle pulse at operation end |
| op_fail | output | 1 | Status bit 0 of last program or erase |
| cfg_we_lo | input | 4 | WE low time in clocks |
| cfg_we_hi | input | 4 | WE high time in clocks |
| cfg_re_lo | input | 4 | RE low time in clocks |
| cfg_re_hi | input | 4 | RE high time in clocks |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_io_out | output | 8 | Byte driven to the I/O lines |
| nf_io_oe | output | 1 | Drive enable for the I/O lines |
| nf_io_in | input | 8 | Byte read from the I/O lines |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
A host request and a low ready/busy line can fall in the same idle cycle, and the sequencer must then decide between accepting and rejecting. The bench provokes this by finishing a reset operation, which leaves the device model busy, and then presenting a program request at once. It expects a reject pulse and no latched byte. A status request in the same busy window must be accepted and must return a byte with the ready bit clear. After the busy line returns high, the same program must be accepted.

// File: rtl/nand_seq_pkg.sv
// Shared types and constants of the NAND command sequencer.
// Assumes an 8-bit device bus and a 23-bit byte address.
package nand_seq_pkg;

    localparam int NF_ADDR_W = 23;

    // Host operation codes
    typedef enum logic [2:0] {
        OP_PROG     = 3'd0,
        OP_RD_LO    = 3'd1,
        OP_RD_HI    = 3'd2,
        OP_RD_SPARE = 3'd3,
        OP_ERASE    = 3'd4,
        OP_RD_ID    = 3'd5,
        OP_RESET    = 3'd6,
        OP_STATUS   = 3'd7
    } nf_op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2,
        ST_WAIT, ST_SCMD, ST_RDATA, ST_FINISH
    } seq_st_e;

    // Device command bytes
    localparam logic [7:0] CB_PROG    = 8'h80;
    localparam logic [7:0] CB_PCONF   = 8'h10;
    localparam logic [7:0] CB_RD_LO   = 8'h00;
    localparam logic [7:0] CB_RD_HI   = 8'h01;
    localparam logic [7:0] CB_RD_SPR  = 8'h50;
    localparam logic [7:0] CB_ERASE   = 8'h60;
    localparam logic [7:0] CB_ECONF   = 8'hD0;
    localparam logic [7:0] CB_ID      = 8'h90;
    localparam logic [7:0] CB_RESET   = 8'hFF;
    localparam logic [7:0] CB_STATUS  = 8'h70;

    // True for operations that end with a status check
    function automatic logic op_checks(nf_op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

    // True for operations allowed while the device is busy
    function automatic logic op_busy_ok(nf_op_e op);
        return (op == OP_RESET) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
// One device bus cycle: a write strobe (command, address or data byte)
// or a read strobe that captures one byte. Low and high times come from
// run-time configuration, each clamped to at least MIN_PW clocks.
// Assumes the caller holds CLE/ALE steady for the whole cycle.
module nand_bus_cycle #(
    parameter int PW_W   = 4,
    parameter int MIN_PW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_read,
    input  logic [7:0]      wbyte,
    input  logic [PW_W-1:0] we_lo,
    input  logic [PW_W-1:0] we_hi,
    input  logic [PW_W-1:0] re_lo,
    input  logic [PW_W-1:0] re_hi,
    input  logic [7:0]      io_in,
    output logic            we_n,
    output logic            re_n,
    output logic [7:0]      io_out,
    output logic            io_oe,
    output logic            busy,
    output logic            done,
    output logic [7:0]      rd_byte
);
    localparam logic [PW_W-1:0] MIN_L = PW_W'(MIN_PW);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    ph_e             ph_q;
    logic            rd_q;
    logic [PW_W-1:0] cnt_q;
    logic [7:0]      out_q;
    logic [7:0]      cap_q;

    function automatic logic [PW_W-1:0] clamp(logic [PW_W-1:0] v);
        return (v < MIN_L) ? MIN_L : v;
    endfunction

    // Phase counter: low phase then high phase, capture on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            rd_q  <= 1'b0;
            cnt_q <= '0;
            out_q <= '0;
            cap_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_LOW;
                    rd_q  <= is_read;
                    cnt_q <= (is_read ? clamp(re_lo) : clamp(we_lo)) - 1'b1;
                    if (!is_read) out_q <= wbyte;
                end
                PH_LOW: if (cnt_q == '0) begin
                    ph_q  <= PH_HIGH;
                    cnt_q <= (rd_q ? clamp(re_hi) : clamp(we_hi)) - 1'b1;
                    if (rd_q) cap_q <= io_in;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_HIGH: if (cnt_q == '0) ph_q <= PH_IDLE;
                         else cnt_q <= cnt_q - 1'b1;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Strobe and bus-drive decode from the phase
    always_comb begin
        we_n    = !(ph_q == PH_LOW && !rd_q);
        re_n    = !(ph_q == PH_LOW && rd_q);
        io_oe   = (ph_q != PH_IDLE) && !rd_q;
        busy    = (ph_q != PH_IDLE);
        done    = (ph_q == PH_HIGH) && (cnt_q == '0);
        io_out  = out_q;
        rd_byte = cap_q;
    end

    // R11
    we_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !$past(we_n, 2));
    // R11
    re_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> !$past(re_n, 2));
    // R12
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

endmodule

// File: rtl/nand_addr_fmt.sv
// Per-operation formatting: command bytes, which address bytes go out,
// the byte selected by the address index, and the effective data count
// (program data limited to the room left in the page).
// Purely combinational; assumes op/addr/count are held by the caller.
module nand_addr_fmt
    import nand_seq_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int PAGE_BYTES = 528
) (
    input  nf_op_e                op,
    input  logic [NF_ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]      count,
    input  logic [1:0]            idx,
    output logic [7:0]            addr_byte,
    output logic [7:0]            cmd1,
    output logic [7:0]            cmd2,
    output logic                  has_addr,
    output logic [1:0]            first_idx,
    output logic [1:0]            last_idx,
    output logic [CNT_W-1:0]      eff_count
);
    localparam logic [CNT_W-1:0] PAGE_L = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] room;

    // Command bytes per operation
    always_comb begin
        unique case (op)
            OP_PROG:     cmd1 = CB_PROG;
            OP_RD_LO:    cmd1 = CB_RD_LO;
            OP_RD_HI:    cmd1 = CB_RD_HI;
            OP_RD_SPARE: cmd1 = CB_RD_SPR;
            OP_ERASE:    cmd1 = CB_ERASE;
            OP_RD_ID:    cmd1 = CB_ID;
            OP_RESET:    cmd1 = CB_RESET;
            default:     cmd1 = CB_STATUS;
        endcase
        cmd2 = (op == OP_ERASE) ? CB_ECONF : CB_PCONF;
    end

    // Address byte range and byte select (A8 skipped)
    always_comb begin
        has_addr  = !op_busy_ok(op);
        first_idx = (op == OP_ERASE) ? 2'd1 : 2'd0;
        last_idx  = (op == OP_RD_ID) ? 2'd0 : 2'd2;
        if (op == OP_RD_ID) begin
            addr_byte = 8'h00;
        end else begin
            unique case (idx)
                2'd0:    addr_byte = addr[7:0];
                2'd1:    addr_byte = addr[16:9];
                default: addr_byte = {2'b00, addr[22:17]};
            endcase
        end
    end

    // Effective byte count: program limited to the page remainder
    always_comb begin
        room = PAGE_L - CNT_W'({addr[8], addr[7:0]});
        unique case (op)
            OP_PROG:   eff_count = (count > room) ? room : count;
            OP_STATUS: eff_count = CNT_W'(1);
            default:   eff_count = count;
        endcase
    end

endmodule

// File: rtl/nand_cmd_seq.sv
// NAND flash command sequencer top. Accepts one host operation at a time,
// sequences command / address / data cycles over the shared 8-bit bus,
// waits on ready/busy, checks status after program and erase.
// Assumes wr_data holds the next byte until wr_ack, and that nf_rb is
// synchronous to clk.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int PW_W       = 4,
    parameter int PAGE_BYTES = 528,
    parameter int WB_CYC     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [NF_ADDR_W-1:0]  req_addr,
    input  logic [CNT_W-1:0]      req_count,
    output logic                  req_ready,
    output logic                  req_reject,
    input  logic [7:0]            wr_data,
    output logic                  wr_ack,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic                  op_done,
    output logic                  op_fail,
    input  logic [PW_W-1:0]       cfg_we_lo,
    input  logic [PW_W-1:0]       cfg_we_hi,
    input  logic [PW_W-1:0]       cfg_re_lo,
    input  logic [PW_W-1:0]       cfg_re_hi,
    output logic                  nf_ce_n,
    output logic                  nf_cle,
    output logic                  nf_ale,
    output logic                  nf_we_n,
    output logic                  nf_re_n,
    output logic [7:0]            nf_io_out,
    output logic                  nf_io_oe,
    input  logic [7:0]            nf_io_in,
    input  logic                  nf_rb
);
    localparam int WB_W = $clog2(WB_CYC + 1);
    localparam logic [WB_W-1:0] WB_L = WB_W'(WB_CYC);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_st_e               st_q;
    nf_op_e                op_q;
    logic [NF_ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [1:0]            aidx_q;
    logic                  issued_q;
    logic [WB_W-1:0]       wb_q;
    logic                  fail_q, done_q, rej_q, chk_q, wack_q;

    logic                  bus_state, cyc_go, cyc_read;
    logic [7:0]            cyc_byte;
    logic                  bc_busy, bc_done;
    logic [7:0]            bc_rd_byte;
    logic [7:0]            addr_byte, cmd1, cmd2;
    logic                  has_addr;
    logic [1:0]            first_idx, last_idx;
    logic [CNT_W-1:0]      eff_count;
    nf_op_e                req_op_e;
    logic                  accept;

    assign req_op_e = nf_op_e'(req_op);
    assign accept   = (st_q == ST_IDLE) && req_valid && (nf_rb || op_busy_ok(req_op_e));

    nand_addr_fmt #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) i_fmt (
        .op(op_q), .addr(addr_q), .count(cnt_q), .idx(aidx_q),
        .addr_byte(addr_byte), .cmd1(cmd1), .cmd2(cmd2), .has_addr(has_addr),
        .first_idx(first_idx), .last_idx(last_idx), .eff_count(eff_count)
    );

    nand_bus_cycle #(.PW_W(PW_W)) i_cyc (
        .clk(clk), .rst_n(rst_n), .start(cyc_go), .is_read(cyc_read),
        .wbyte(cyc_byte), .we_lo(cfg_we_lo), .we_hi(cfg_we_hi),
        .re_lo(cfg_re_lo), .re_hi(cfg_re_hi), .io_in(nf_io_in),
        .we_n(nf_we_n), .re_n(nf_re_n), .io_out(nf_io_out), .io_oe(nf_io_oe),
        .busy(bc_busy), .done(bc_done), .rd_byte(bc_rd_byte)
    );

    // Bus cycle launch and byte select for the current state
    always_comb begin
        bus_state = (st_q == ST_CMD1) || (st_q == ST_ADDR) || (st_q == ST_WDATA) ||
                    (st_q == ST_CMD2) || (st_q == ST_SCMD) || (st_q == ST_RDATA);
        cyc_go    = bus_state && !bc_busy && !issued_q;
        cyc_read  = (st_q == ST_RDATA);
        unique case (st_q)
            ST_CMD1:  cyc_byte = cmd1;
            ST_ADDR:  cyc_byte = addr_byte;
            ST_WDATA: cyc_byte = wr_data;
            ST_CMD2:  cyc_byte = cmd2;
            ST_SCMD:  cyc_byte = CB_STATUS;
            default:  cyc_byte = 8'h00;
        endcase
    end

    // Operation sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            op_q     <= OP_RESET;
            addr_q   <= '0;
            cnt_q    <= '0;
            aidx_q   <= '0;
            issued_q <= 1'b0;
            wb_q     <= '0;
            fail_q   <= 1'b0;
            done_q   <= 1'b0;
            rej_q    <= 1'b0;
            chk_q    <= 1'b0;
            wack_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            wack_q <= cyc_go && (st_q == ST_WDATA);
            if (cyc_go)  issued_q <= 1'b1;
            if (bc_done) issued_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    st_q   <= ST_CMD1;
                    op_q   <= req_op_e;
                    addr_q <= req_addr;
                    cnt_q  <= req_count;
                    chk_q  <= 1'b0;
                    if (op_checks(req_op_e)) fail_q <= 1'b0;
                end else if (req_valid) begin
                    rej_q <= 1'b1;
                end
                ST_CMD1: if (bc_done) begin
                    cnt_q <= eff_count;
                    if (has_addr) begin
                        st_q   <= ST_ADDR;
                        aidx_q <= first_idx;
                    end else if (op_q == OP_STATUS) begin
                        st_q <= ST_RDATA;
                    end else begin
                        st_q <= ST_FINISH;
                    end
                end
                ST_ADDR: if (bc_done) begin
                    if (aidx_q == last_idx) begin
                        unique case (op_q)
                            OP_PROG:  st_q <= (cnt_q == '0) ? ST_CMD2 : ST_WDATA;
                            OP_ERASE: st_q <= ST_CMD2;
                            OP_RD_ID: st_q <= (cnt_q == '0) ? ST_FINISH : ST_RDATA;
                            default: begin
                                st_q <= ST_WAIT;
                                wb_q <= WB_L;
                            end
                        endcase
                    end else begin
                        aidx_q <= aidx_q + 2'd1;
                    end
                end
                ST_WDATA: if (bc_done) begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) st_q <= ST_CMD2;
                end
                ST_CMD2: if (bc_done) begin
                    st_q <= ST_WAIT;
                    wb_q <= WB_L;
                end
                ST_WAIT: begin
                    if (wb_q != '0) begin
                        wb_q <= wb_q - 1'b1;
                    end else if (nf_rb) begin
                        if (op_checks(op_q)) st_q <= ST_SCMD;
                        else st_q <= (cnt_q == '0) ? ST_FINISH : ST_RDATA;
                    end
                end
                ST_SCMD: if (bc_done) begin
                    st_q  <= ST_RDATA;
                    cnt_q <= ONE;
                    chk_q <= 1'b1;
                end
                ST_RDATA: if (bc_done) begin
                    cnt_q <= cnt_q - ONE;
                    if (chk_q) fail_q <= bc_rd_byte[0];
                    if (cnt_q == ONE) st_q <= ST_FINISH;
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Host-side and latch-enable outputs
    always_comb begin
        req_ready  = (st_q == ST_IDLE);
        req_reject = rej_q;
        wr_ack     = wack_q;
        rd_valid   = bc_done && (st_q == ST_RDATA) && !chk_q;
        rd_data    = bc_rd_byte;
        op_done    = done_q;
        op_fail    = fail_q;
        nf_ce_n    = (st_q == ST_IDLE) || (st_q == ST_FINISH);
        nf_cle     = (st_q == ST_CMD1) || (st_q == ST_CMD2) || (st_q == ST_SCMD);
        nf_ale     = (st_q == ST_ADDR);
    end

    // R1
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !nf_rb && !op_busy_ok(op_q)) |-> (nf_we_n && nf_re_n));
    // R9
    reject_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !$past(nf_rb));
    // R12
    ce_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !nf_io_oe);

endmodule

// File: tb/test_nand_cmd_seq.sv
// Directed bench with a behavioural flash model (busy timer, status, data).
module test_nand_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [22:0] req_addr = '0;
    logic [9:0]  req_count = '0;
    logic        req_ready, req_reject, wr_ack, rd_valid, op_done, op_fail;
    logic [7:0]  wr_data, rd_data;
    logic [3:0]  cfg_we_lo = 4'd3, cfg_we_hi = 4'd2, cfg_re_lo = 4'd3, cfg_re_hi = 4'd2;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in;
    logic        nf_rb;

    always #5 clk = ~clk;

    nand_cmd_seq i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_count(req_count), .req_ready(req_ready),
        .req_reject(req_reject), .wr_data(wr_data), .wr_ack(wr_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .op_done(op_done), .op_fail(op_fail),
        .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi), .cfg_re_lo(cfg_re_lo),
        .cfg_re_hi(cfg_re_hi), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
    );

    int n_chk = 0, n_bad = 0;
    int ev_n, rd_n, wr_idx, ce_rises, busy_strobes, bad_oe;
    int we_min, we_max, re_min, re_max, we_run, re_run;
    logic [1:0] ev_kind [0:1023];
    logic [7:0] ev_byte [0:1023];
    logic [7:0] rd_buf  [0:63];
    logic       inject_fail = 1'b0;
    logic [7:0] last_cmd;
    int         addr_n, rd_idx, busy_cnt;
    logic       prev_we, prev_re, prev_ce;

    assign wr_data = 8'(wr_idx) ^ 8'h5A;

    // Flash model and bus monitors, evaluated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            nf_rb = 1'b1; nf_io_in = 8'hFF; busy_cnt = 0; last_cmd = 8'h00;
            addr_n = 0; rd_idx = 0; prev_we = 1'b1; prev_re = 1'b1; prev_ce = 1'b1;
        end else begin
            if (busy_cnt != 0) begin
                busy_cnt = busy_cnt - 1;
                if (busy_cnt == 0) nf_rb = 1'b1;
            end
            if (nf_we_n && !prev_we) begin
                logic [1:0] k;
                k = (nf_cle && !nf_ale) ? 2'd0 : (!nf_cle && nf_ale) ? 2'd1 :
                    (!nf_cle && !nf_ale) ? 2'd2 : 2'd3;
                if (!nf_io_oe) k = 2'd3;
                if (ev_n < 1024) begin ev_kind[ev_n] = k; ev_byte[ev_n] = nf_io_out; end
                ev_n++;
                if (k == 2'd0) begin
                    last_cmd = nf_io_out; addr_n = 0; rd_idx = 0;
                    if (nf_io_out == 8'h10 || nf_io_out == 8'hD0 || nf_io_out == 8'hFF) begin
                        nf_rb = 1'b0; busy_cnt = 30;
                    end
                end else if (k == 2'd1) begin
                    addr_n++;
                    if (addr_n == 3 && (last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50)) begin
                        nf_rb = 1'b0; busy_cnt = 30;
                    end
                end
            end
            if (!nf_re_n && prev_re) begin
                if (last_cmd == 8'h70) nf_io_in = {1'b1, nf_rb, 5'b0, inject_fail};
                else if (last_cmd == 8'h90) nf_io_in = 8'hE0 + 8'(rd_idx);
                else nf_io_in = 8'h30 + 8'(rd_idx);
                rd_idx++;
            end
            if (!nf_we_n) we_run++;
            else if (we_run != 0) begin
                if (we_run < we_min) we_min = we_run;
                if (we_run > we_max) we_max = we_run;
                we_run = 0;
            end
            if (!nf_re_n) re_run++;
            else if (re_run != 0) begin
                if (re_run < re_min) re_min = re_run;
                if (re_run > re_max) re_max = re_run;
                re_run = 0;
            end
            if (nf_ce_n && !prev_ce) ce_rises++;
            if ((!nf_we_n || !nf_re_n) && !nf_rb) busy_strobes++;
            if (nf_io_oe && !nf_re_n) bad_oe++;
            if (rd_valid && rd_n < 64) begin rd_buf[rd_n] = rd_data; rd_n++; end
            if (wr_ack) wr_idx++;
            prev_we = nf_we_n; prev_re = nf_re_n; prev_ce = nf_ce_n;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ev_n = 0; rd_n = 0; wr_idx = 0; ce_rises = 0; busy_strobes = 0; bad_oe = 0;
        we_min = 99; we_max = 0; re_min = 99; re_max = 0; we_run = 0; re_run = 0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [22:0] a, input int cnt);
        int t;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_count = 10'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!op_done && t < 20000) begin @(negedge clk); t++; end
        chk(op_done, "op_done timeout", t, 0);
        chk(nf_ce_n && !nf_io_oe, "R12 idle release", {nf_ce_n, nf_io_oe}, 2);
    endtask

    task automatic ev_is(input int i, input logic [1:0] k, input logic [7:0] b, input string req);
        chk(ev_kind[i] == k && ev_byte[i] == b, req, {ev_kind[i], ev_byte[i]}, {k, b});
    endtask

    task automatic wait_ready();
        int t = 0;
        while (!nf_rb && t < 1000) begin @(negedge clk); t++; end
    endtask

    localparam logic [22:0] ADR = {6'h15, 8'hC3, 1'b1, 8'h10};

    task automatic t_reset_state();
        chk(nf_ce_n && nf_we_n && nf_re_n && !nf_io_oe && req_ready && !op_done,
            "R12 reset state", {nf_ce_n, nf_we_n, nf_re_n, nf_io_oe, req_ready, op_done}, 6'b111010);
    endtask

    task automatic t_program();
        run_op(3'd0, ADR, 4);
        chk(ev_n == 10, "R3 program cycle count", ev_n, 10);
        ev_is(0, 2'd0, 8'h80, "R1 R3 program cmd");
        ev_is(1, 2'd1, 8'h10, "R2 addr byte0");
        ev_is(2, 2'd1, 8'hC3, "R2 addr byte1");
        ev_is(3, 2'd1, 8'h15, "R2 addr byte2");
        for (int i = 0; i < 4; i++) ev_is(4 + i, 2'd2, 8'(i) ^ 8'h5A, "R1 R3 data byte");
        ev_is(8, 2'd0, 8'h10, "R3 confirm");
        ev_is(9, 2'd0, 8'h70, "R7 status cmd");
        chk(!op_fail, "R7 pass", op_fail, 0);
        chk(busy_strobes == 0, "R6 quiet while busy", busy_strobes, 0);
        chk(ce_rises == 1, "R12 single CE rise", ce_rises, 1);
        chk(bad_oe == 0, "R12 no drive with RE low", bad_oe, 0);
    endtask

    task automatic t_prog_fail();
        inject_fail = 1'b1;
        run_op(3'd0, ADR, 1);
        inject_fail = 1'b0;
        chk(op_fail, "R7 fail reported", op_fail, 1);
    endtask

    task automatic t_erase();
        run_op(3'd4, ADR, 0);
        chk(ev_n == 5, "R4 erase cycle count", ev_n, 5);
        ev_is(0, 2'd0, 8'h60, "R4 erase cmd");
        ev_is(1, 2'd1, 8'hC3, "R4 addr byte1");
        ev_is(2, 2'd1, 8'h15, "R4 addr byte2");
        ev_is(3, 2'd0, 8'hD0, "R4 confirm");
        ev_is(4, 2'd0, 8'h70, "R7 erase status");
        chk(!op_fail, "R7 erase pass clears fail", op_fail, 0);
        chk(busy_strobes == 0, "R6 erase quiet", busy_strobes, 0);
    endtask

    task automatic t_reads();
        logic [7:0] cb [0:2];
        cb[0] = 8'h00; cb[1] = 8'h01; cb[2] = 8'h50;
        for (int v = 0; v < 3; v++) begin
            run_op(3'(v + 1), ADR, 3);
            ev_is(0, 2'd0, cb[v], "R5 read cmd");
            chk(ev_n == 4, "R5 read cycle count", ev_n, 4);
            chk(rd_n == 3, "R5 read byte count", rd_n, 3);
            for (int i = 0; i < 3; i++)
                chk(rd_buf[i] == 8'h30 + 8'(i), "R5 R10 read data", rd_buf[i], 8'h30 + i);
            chk(busy_strobes == 0, "R6 read quiet", busy_strobes, 0);
        end
    endtask

    task automatic t_read_id();
        run_op(3'd5, ADR, 2);
        chk(ev_n == 2, "R10 id cycle count", ev_n, 2);
        ev_is(0, 2'd0, 8'h90, "R10 id cmd");
        ev_is(1, 2'd1, 8'h00, "R10 id addr");
        chk(rd_n == 2 && rd_buf[0] == 8'hE0 && rd_buf[1] == 8'hE1, "R10 id data",
            {rd_buf[0], rd_buf[1]}, 16'hE0E1);
    endtask

    task automatic t_page_limit();
        // column 500 = {A8=1, 8'hF4}: room 28
        run_op(3'd0, {6'h01, 8'h02, 1'b1, 8'hF4}, 40);
        chk(ev_n == 28 + 6, "R8 limited cycle count", ev_n, 34);
        chk(wr_idx == 28, "R8 host bytes requested", wr_idx, 28);
        ev_is(4 + 27, 2'd2, 8'd27 ^ 8'h5A, "R8 last data byte");
        ev_is(4 + 28, 2'd0, 8'h10, "R8 confirm after limit");
    endtask

    task automatic t_pulse_width();
        cfg_we_lo = 4'd0; cfg_we_hi = 4'd0; cfg_re_lo = 4'd1; cfg_re_hi = 4'd0;
        run_op(3'd1, ADR, 2);
        chk(we_min == 2 && we_max == 2, "R11 WE clamped to 2", we_max, 2);
        chk(re_min == 2 && re_max == 2, "R11 RE clamped to 2", re_max, 2);
        chk(rd_n == 2 && rd_buf[1] == 8'h31, "R10 data at min RE", rd_buf[1], 8'h31);
        cfg_we_lo = 4'd6; cfg_re_lo = 4'd5;
        run_op(3'd4, ADR, 0);
        chk(we_min == 6 && we_max == 6, "R11 WE low 6", we_max, 6);
        chk(re_min == 5 && re_max == 5, "R11 RE low 5", re_max, 5);
        cfg_we_lo = 4'd3; cfg_we_hi = 4'd2; cfg_re_lo = 4'd3; cfg_re_hi = 4'd2;
    endtask

    task automatic t_busy_reject();
        run_op(3'd6, ADR, 0);
        chk(ev_n == 1 && ev_kind[0] == 2'd0 && ev_byte[0] == 8'hFF, "R9 reset cmd", ev_byte[0], 8'hFF);
        chk(!nf_rb, "R9 device busy after reset", nf_rb, 0);
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_addr = ADR; req_count = 10'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject, "R9 reject while busy", req_reject, 1);
        repeat (4) @(negedge clk);
        chk(ev_n == 0 && req_ready, "R9 no bus cycle after reject", ev_n, 0);
        run_op(3'd7, ADR, 0);
        ev_is(0, 2'd0, 8'h70, "R9 status accepted");
        chk(rd_n == 1 && rd_buf[0] == 8'h80, "R9 status byte busy", rd_buf[0], 8'h80);
        wait_ready();
        run_op(3'd0, ADR, 1);
        chk(ev_n == 7 && ev_byte[0] == 8'h80, "R9 accepted when ready", ev_n, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_prog_fail();
        t_erase();
        t_reads();
        t_read_id();
        t_page_limit();
        t_pulse_width();
        t_busy_reject();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule